// File: doc/BRIEF.md
# Transactional Store Buffer

This block sits on one core's path to memory and turns a run of loads and stores into a single all-or-nothing update. A begin command opens a transaction and records a resume address. While the transaction is open, stores go into a small private buffer and never reach memory. Loads return buffered data when the address was already stored in the transaction, and every loaded address joins a monitored read set. A snoop port reports writes made by other agents. A snooped write to any monitored or buffered address cancels the transaction. The block then reports the resume address and a reason code.

A commit command copies the buffered stores to memory in one uninterrupted burst. While the burst runs, the grant to the other memory requester is held low, so no one sees memory with only part of the update applied. An explicit abort command, a conflict, or a full buffer throws away every buffered store and every read-set entry without writing memory. Outside a transaction, core accesses pass straight to memory.

The controller has three states. `S_IDLE` means no transaction is open. `S_ACTIVE` means a transaction is open. `S_DRAIN` means a commit burst is in progress. The transitions are:
- begin: `S_IDLE` to `S_ACTIVE`.
- commit with stores buffered: `S_ACTIVE` to `S_DRAIN`.
- empty commit, explicit abort, conflict or overflow: `S_ACTIVE` to `S_IDLE`.
- last buffered entry written: `S_DRAIN` to `S_IDLE`.

Top module: `txn_store_buffer`

## Requirements
- R1: A begin command (cmd_op = 1) in idle latches cmd_target. Every abort raises abort_valid for exactly one cycle, in the cycle after the event that caused it. With that pulse, abort_target shows the latched address and txn_active is already low.
- R2: While txn_active is high, mem_we stays low, so stores made in a transaction never reach memory before commit.
- R3: In a transaction, a load of an address already stored returns the newest buffered data on core_rdata in the same cycle. A store to an address already buffered replaces that entry's data and takes no new entry.
- R4: Each address loaded in a transaction enters the read set once. A snooped write to any of these addresses aborts with reason 1.
- R5: A snooped write to a buffered store address aborts with reason 2. If the address is in both sets, reason 1 wins. A snooped write to an address in neither set has no effect.
- R6: A commit (cmd_op = 2) with N > 0 buffered entries drives mem_we for N consecutive cycles, starting in the cycle after the commit. The entries go out in the order their addresses were first stored. During those N cycles core_ready and ext_grant are low.
- R7: After the last entry of a commit is written, the block is idle with both sets empty. A snoop to an address read during that transaction then causes no abort.
- R8: An explicit abort command (cmd_op = 3) aborts with reason 0 and leaves memory unchanged. A later load outside the transaction returns the old value.
- R9: With 8 write entries in use, a store to a new address aborts with reason 3. With 8 read entries in use, a load of a new address aborts with reason 3. An access to an address already held in the full set does not abort.
- R10: In idle, core stores write memory directly and loads read memory. Snoops, commit commands and abort commands have no effect.
- R11: A commit with an empty write buffer returns to idle at the next edge without any memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Transaction command valid |
| cmd_op | input | 2 | 1 begin, 2 commit, 3 abort |
| cmd_target | input | AW | Resume address carried by begin |
| req_valid | input | 1 | Core access valid |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | AW | Core access address |
| req_wdata | input | DW | Core store data |
| core_rdata | output | DW | Load data (same cycle) |
| core_ready | output | 1 | Low while a commit burst runs |
| txn_active | output | 1 | Transaction open |
| snoop_valid | input | 1 | External write observed |
| snoop_addr | input | AW | Address of the external write |
| abort_valid | output | 1 | One-cycle abort pulse |
| abort_reason | output | 3 | 0 explicit, 1 read conflict, 2 write conflict, 3 overflow |
| abort_target | output | AW | Resume address for the aborted transaction |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data (combinational) |
| ext_request | input | 1 | Other requester wants memory |
| ext_grant | output | 1 | Grant to the other requester |

## Verification
Several stimulus patterns are used, and each one separates a specific fault:
- A transaction that stores, overwrites and re-loads the same address tells forwarding apart from a fall-through to memory. It also tells an in-place overwrite apart from a duplicate entry, because the commit burst would then run too long or in the wrong order.
- Snoops aimed at a loaded-only address, a stored-only address, an address in both sets, and an unrelated address check each conflict reason, its priority, and that false hits do not occur.
- Filling each set to eight entries and then issuing a new address and a repeated address places the overflow limit exactly.
- An empty commit and a set of idle-mode accesses show that committed and ignored paths leave no trace in memory.

// File: rtl/swb_pkg.sv
package swb_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACTIVE = 2'd1,
        S_DRAIN  = 2'd2
    } swb_state_e;

    localparam logic [1:0] OP_BEGIN  = 2'd1;
    localparam logic [1:0] OP_COMMIT = 2'd2;
    localparam logic [1:0] OP_ABORT  = 2'd3;

    localparam logic [2:0] RSN_EXPLICIT = 3'd0;
    localparam logic [2:0] RSN_READ     = 3'd1;
    localparam logic [2:0] RSN_WRITE    = 3'd2;
    localparam logic [2:0] RSN_OVERFLOW = 3'd3;
endpackage

// File: rtl/swb_write_set.sv
module swb_write_set #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [AW-1:0] look_addr,
    input  logic [DW-1:0] wr_data,
    output logic          look_hit,
    output logic [DW-1:0] look_data,
    input  logic [AW-1:0] snoop_addr,
    output logic          snoop_hit,
    input  logic [IW-1:0] drain_idx,
    output logic [AW-1:0] drain_addr,
    output logic [DW-1:0] drain_data,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] snp_vec;
    logic [IW-1:0] hit_idx;

    // per-entry comparators
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic used;
        assign used       = (CW'(i) < cnt_q);
        assign hit_vec[i] = used && (addr_q[i] == look_addr);
        assign snp_vec[i] = used && (addr_q[i] == snoop_addr);
    end

    always_comb begin
        look_data = '0;
        hit_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                look_data = data_q[i];
                hit_idx   = IW'(i);
            end
        end
    end

    assign look_hit   = |hit_vec;
    assign snoop_hit  = |snp_vec;
    assign count      = cnt_q;
    assign full       = (cnt_q == CW'(DEPTH));
    assign drain_addr = addr_q[drain_idx];
    assign drain_data = data_q[drain_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (wr_en && !look_hit && !full) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // storage carries no reset: entries above the count are never read
    always_ff @(posedge clk) begin
        if (rst_n && !clear && wr_en) begin
            if (look_hit) begin
                data_q[hit_idx] <= wr_data;
            end else if (!full) begin
                addr_q[cnt_q[IW-1:0]] <= look_addr;
                data_q[cnt_q[IW-1:0]] <= wr_data;
            end
        end
    end

    // a full buffer never grows or shrinks without a clear
    p_ws_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clear) |=> full);
endmodule

// File: rtl/swb_read_set.sv
module swb_read_set #(
    parameter int AW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          add_en,
    input  logic [AW-1:0] look_addr,
    output logic          look_hit,
    input  logic [AW-1:0] snoop_addr,
    output logic          snoop_hit,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [AW-1:0] addr_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] snp_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic used;
        assign used       = (CW'(i) < cnt_q);
        assign hit_vec[i] = used && (addr_q[i] == look_addr);
        assign snp_vec[i] = used && (addr_q[i] == snoop_addr);
    end

    assign look_hit  = |hit_vec;
    assign snoop_hit = |snp_vec;
    assign count     = cnt_q;
    assign full      = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (add_en && !look_hit && !full) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && !clear && add_en && !look_hit && !full) begin
            addr_q[cnt_q[IW-1:0]] <= look_addr;
        end
    end

    // the controller never asks to record an address already held
    p_rs_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |-> !look_hit);
endmodule

// File: rtl/swb_ctrl.sv
module swb_ctrl
    import swb_pkg::*;
#(
    parameter int AW     = 8,
    parameter int WDEPTH = 8,
    localparam int CW    = $clog2(WDEPTH + 1),
    localparam int IW    = $clog2(WDEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_target,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          snoop_valid,
    input  logic          ws_look_hit,
    input  logic          ws_full,
    input  logic [CW-1:0] ws_count,
    input  logic          ws_snoop_hit,
    input  logic          rs_look_hit,
    input  logic          rs_full,
    input  logic          rs_snoop_hit,
    output swb_state_e    state,
    output logic          ws_wr_en,
    output logic          rs_add_en,
    output logic          sets_clear,
    output logic [IW-1:0] drain_idx,
    output logic          drain_last,
    output logic          abort_valid,
    output logic [2:0]    abort_reason,
    output logic [AW-1:0] abort_target
);
    swb_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [AW-1:0] tgt_q, tgt_d;
    logic          ab_q, ab_d;
    logic [2:0]    rsn_q, rsn_d;

    assign drain_last = ((CW'(idx_q) + CW'(1)) == ws_count);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            tgt_q   <= '0;
            ab_q    <= 1'b0;
            rsn_q   <= RSN_EXPLICIT;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            tgt_q   <= tgt_d;
            ab_q    <= ab_d;
            rsn_q   <= rsn_d;
        end
    end

    // next state and per-cycle actions
    always_comb begin
        state_d    = state_q;
        idx_d      = idx_q;
        tgt_d      = tgt_q;
        ab_d       = 1'b0;
        rsn_d      = rsn_q;
        ws_wr_en   = 1'b0;
        rs_add_en  = 1'b0;
        sets_clear = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid && cmd_op == OP_BEGIN) begin
                    state_d    = S_ACTIVE;
                    tgt_d      = cmd_target;
                    sets_clear = 1'b1;
                end
            end
            S_ACTIVE: begin
                if (snoop_valid && rs_snoop_hit) begin
                    state_d = S_IDLE; sets_clear = 1'b1; ab_d = 1'b1; rsn_d = RSN_READ;
                end else if (snoop_valid && ws_snoop_hit) begin
                    state_d = S_IDLE; sets_clear = 1'b1; ab_d = 1'b1; rsn_d = RSN_WRITE;
                end else if (cmd_valid && cmd_op == OP_ABORT) begin
                    state_d = S_IDLE; sets_clear = 1'b1; ab_d = 1'b1; rsn_d = RSN_EXPLICIT;
                end else if (cmd_valid && cmd_op == OP_COMMIT) begin
                    if (ws_count == '0) begin
                        state_d    = S_IDLE;
                        sets_clear = 1'b1;
                    end else begin
                        state_d = S_DRAIN;
                        idx_d   = '0;
                    end
                end else if (req_valid && req_write) begin
                    if (!ws_look_hit && ws_full) begin
                        state_d = S_IDLE; sets_clear = 1'b1; ab_d = 1'b1; rsn_d = RSN_OVERFLOW;
                    end else begin
                        ws_wr_en = 1'b1;
                    end
                end else if (req_valid) begin
                    if (!rs_look_hit && rs_full) begin
                        state_d = S_IDLE; sets_clear = 1'b1; ab_d = 1'b1; rsn_d = RSN_OVERFLOW;
                    end else begin
                        rs_add_en = !rs_look_hit;
                    end
                end
            end
            S_DRAIN: begin
                if (drain_last) begin
                    state_d    = S_IDLE;
                    idx_d      = '0;
                    sets_clear = 1'b1;
                end else begin
                    idx_d = idx_q + IW'(1);
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign state        = state_q;
    assign drain_idx    = idx_q;
    assign abort_valid  = ab_q;
    assign abort_reason = rsn_q;
    assign abort_target = tgt_q;

    p_abort_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ab_q |=> !ab_q);
    p_drain_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DRAIN && $past(state_q) != S_DRAIN) |-> $past(state_q) == S_ACTIVE);
endmodule

// File: rtl/txn_store_buffer.sv
module txn_store_buffer
    import swb_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 16,
    parameter int WDEPTH = 8,
    parameter int RDEPTH = 8,
    localparam int WCW   = $clog2(WDEPTH + 1),
    localparam int RCW   = $clog2(RDEPTH + 1),
    localparam int WIW   = $clog2(WDEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_target,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] core_rdata,
    output logic          core_ready,
    output logic          txn_active,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    output logic          abort_valid,
    output logic [2:0]    abort_reason,
    output logic [AW-1:0] abort_target,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          ext_request,
    output logic          ext_grant
);
    swb_state_e     state;
    logic           ws_wr_en, rs_add_en, sets_clear, drain_last;
    logic [WIW-1:0] drain_idx;
    logic           ws_look_hit, ws_snoop_hit, ws_full;
    logic [DW-1:0]  ws_look_data, drain_data;
    logic [AW-1:0]  drain_addr;
    logic [WCW-1:0] ws_count;
    logic           rs_look_hit, rs_snoop_hit, rs_full;
    logic [RCW-1:0] rs_count;

    swb_ctrl #(.AW(AW), .WDEPTH(WDEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_target(cmd_target),
        .req_valid(req_valid), .req_write(req_write), .snoop_valid(snoop_valid),
        .ws_look_hit(ws_look_hit), .ws_full(ws_full), .ws_count(ws_count),
        .ws_snoop_hit(ws_snoop_hit), .rs_look_hit(rs_look_hit), .rs_full(rs_full),
        .rs_snoop_hit(rs_snoop_hit), .state(state), .ws_wr_en(ws_wr_en),
        .rs_add_en(rs_add_en), .sets_clear(sets_clear), .drain_idx(drain_idx),
        .drain_last(drain_last), .abort_valid(abort_valid),
        .abort_reason(abort_reason), .abort_target(abort_target)
    );

    swb_write_set #(.AW(AW), .DW(DW), .DEPTH(WDEPTH)) u_wset (
        .clk(clk), .rst_n(rst_n), .clear(sets_clear), .wr_en(ws_wr_en),
        .look_addr(req_addr), .wr_data(req_wdata), .look_hit(ws_look_hit),
        .look_data(ws_look_data), .snoop_addr(snoop_addr), .snoop_hit(ws_snoop_hit),
        .drain_idx(drain_idx), .drain_addr(drain_addr), .drain_data(drain_data),
        .count(ws_count), .full(ws_full)
    );

    swb_read_set #(.AW(AW), .DEPTH(RDEPTH)) u_rset (
        .clk(clk), .rst_n(rst_n), .clear(sets_clear), .add_en(rs_add_en),
        .look_addr(req_addr), .look_hit(rs_look_hit), .snoop_addr(snoop_addr),
        .snoop_hit(rs_snoop_hit), .count(rs_count), .full(rs_full)
    );

    // memory port steering
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
        unique case (state)
            S_DRAIN: begin
                mem_we    = 1'b1;
                mem_addr  = drain_addr;
                mem_wdata = drain_data;
            end
            S_IDLE:   mem_we = req_valid && req_write;
            default:  mem_we = 1'b0;
        endcase
    end

    assign txn_active = (state == S_ACTIVE);
    assign core_ready = (state != S_DRAIN);
    assign ext_grant  = ext_request && (state != S_DRAIN);
    assign core_rdata = (txn_active && ws_look_hit) ? ws_look_data : mem_rdata;

    p_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_active |-> !mem_we);
    p_grant_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ready |-> !ext_grant);
    p_abort_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid |-> (!txn_active && core_ready));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN && drain_last) |=> (ws_count == '0 && rs_count == '0 && !txn_active));
    p_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_active && ws_full && req_valid && req_write && !ws_look_hit &&
         !snoop_valid && !cmd_valid) |=> (abort_valid && abort_reason == RSN_OVERFLOW));
endmodule

// File: tb/txn_store_buffer_test.sv
module txn_store_buffer_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_target = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] core_rdata;
    logic          core_ready, txn_active;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          abort_valid;
    logic [2:0]    abort_reason;
    logic [AW-1:0] abort_target;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          ext_request = 1'b1;
    logic          ext_grant;

    logic [DW-1:0] mem_model [256];
    int            wr_cnt = 0;
    int            total = 0;
    int            bad = 0;
    bit            finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    assign mem_rdata = mem_model[mem_addr];
    always @(posedge clk) begin
        if (mem_we) begin
            mem_model[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    txn_store_buffer #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_target(cmd_target), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .core_rdata(core_rdata),
        .core_ready(core_ready), .txn_active(txn_active), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .abort_valid(abort_valid), .abort_reason(abort_reason),
        .abort_target(abort_target), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ext_request(ext_request),
        .ext_grant(ext_grant)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] tgt);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_target = tgt;
        @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk); req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic load(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk); req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1 d = core_rdata;
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic snoop(input logic [AW-1:0] a);
        @(negedge clk); snoop_valid = 1'b1; snoop_addr = a;
        @(negedge clk); snoop_valid = 1'b0;
    endtask

    task automatic expect_abort(input string tag, input logic [2:0] rsn, input logic [AW-1:0] tgt);
        check(abort_valid === 1'b1, tag, abort_valid, 1);
        check(abort_reason === rsn, tag, abort_reason, rsn);
        check(abort_target === tgt, tag, abort_target, tgt);
        check(txn_active === 1'b0, tag, txn_active, 0);
        @(negedge clk);
        check(abort_valid === 1'b0, {tag, " pulse width"}, abort_valid, 0);
    endtask

    task automatic t_reset;
        check(txn_active === 1'b0, "R1 reset idle", txn_active, 0);
        check(abort_valid === 1'b0, "R1 reset no abort", abort_valid, 0);
        check(core_ready === 1'b1 && ext_grant === 1'b1, "R6 reset grant", ext_grant, 1);
    endtask

    task automatic t_idle_path;
        logic [DW-1:0] d;
        int w0;
        store(8'h05, 16'h00AA);
        check(mem_model[5] === 16'h00AA, "R10 idle store", mem_model[5], 16'h00AA);
        load(8'h05, d);
        check(d === 16'h00AA, "R10 idle load", d, 16'h00AA);
        w0 = wr_cnt;
        snoop(8'h05);
        check(abort_valid === 1'b0, "R10 idle snoop", abort_valid, 0);
        send_cmd(2'd2, 8'h00);
        check(txn_active === 1'b0 && wr_cnt == w0, "R10 idle commit", wr_cnt, w0);
        send_cmd(2'd3, 8'h00);
        check(abort_valid === 1'b0, "R10 idle abort", abort_valid, 0);
    endtask

    task automatic t_commit;
        logic [DW-1:0] d;
        int w0;
        mem_model[8'h30] = 16'h3030;
        mem_model[8'h10] = 16'h1111;
        send_cmd(2'd1, 8'h40);
        check(txn_active === 1'b1, "R1 begin", txn_active, 1);
        w0 = wr_cnt;
        store(8'h10, 16'h0011);
        store(8'h20, 16'h0022);
        store(8'h10, 16'h0033);
        load(8'h10, d);
        check(d === 16'h0033, "R3 forward newest", d, 16'h0033);
        load(8'h20, d);
        check(d === 16'h0022, "R3 forward", d, 16'h0022);
        load(8'h30, d);
        check(d === 16'h3030, "R3 miss reads memory", d, 16'h3030);
        check(wr_cnt == w0 && mem_model[8'h10] === 16'h1111, "R2 stores hidden", wr_cnt, w0);
        send_cmd(2'd2, 8'h00);
        check(mem_we === 1'b1 && mem_addr === 8'h10 && mem_wdata === 16'h0033,
              "R6 drain entry0", mem_addr, 8'h10);
        check(core_ready === 1'b0 && ext_grant === 1'b0, "R6 grant held low", ext_grant, 0);
        @(negedge clk);
        check(mem_we === 1'b1 && mem_addr === 8'h20 && mem_wdata === 16'h0022,
              "R6 drain entry1", mem_addr, 8'h20);
        check(ext_grant === 1'b0, "R6 grant held low 2", ext_grant, 0);
        @(negedge clk);
        check(core_ready === 1'b1 && ext_grant === 1'b1 && mem_we === 1'b0,
              "R6 burst length", mem_we, 0);
        check(wr_cnt == w0 + 2, "R3 overwrite no new entry", wr_cnt, w0 + 2);
        check(mem_model[8'h10] === 16'h0033 && mem_model[8'h20] === 16'h0022,
              "R6 memory updated", mem_model[8'h10], 16'h0033);
        check(txn_active === 1'b0, "R7 idle after commit", txn_active, 0);
        snoop(8'h30);
        check(abort_valid === 1'b0, "R7 read set cleared", abort_valid, 0);
    endtask

    task automatic t_conflicts;
        logic [DW-1:0] d;
        mem_model[8'h09] = 16'h0909;
        send_cmd(2'd1, 8'h55);
        load(8'h07, d);
        snoop(8'h08);
        check(abort_valid === 1'b0 && txn_active === 1'b1, "R5 unrelated snoop", abort_valid, 0);
        snoop(8'h07);
        expect_abort("R4 read conflict", 3'd1, 8'h55);

        send_cmd(2'd1, 8'h66);
        store(8'h09, 16'hBEEF);
        snoop(8'h09);
        expect_abort("R5 write conflict", 3'd2, 8'h66);
        check(mem_model[8'h09] === 16'h0909, "R5 store discarded", mem_model[8'h09], 16'h0909);

        send_cmd(2'd1, 8'h77);
        store(8'h0A, 16'h1234);
        load(8'h0A, d);
        snoop(8'h0A);
        expect_abort("R5 read wins", 3'd1, 8'h77);
    endtask

    task automatic t_explicit;
        logic [DW-1:0] d;
        int w0;
        mem_model[8'h0C] = 16'h0C0C;
        w0 = wr_cnt;
        send_cmd(2'd1, 8'h88);
        store(8'h0C, 16'h0077);
        send_cmd(2'd3, 8'h00);
        expect_abort("R8 explicit", 3'd0, 8'h88);
        check(wr_cnt == w0, "R8 no memory write", wr_cnt, w0);
        load(8'h0C, d);
        check(d === 16'h0C0C, "R8 old value", d, 16'h0C0C);
    endtask

    task automatic t_overflow;
        logic [DW-1:0] d;
        send_cmd(2'd1, 8'h99);
        for (int i = 0; i < 8; i++) store(8'(100 + i), 16'(i));
        store(8'd100, 16'hABCD);
        check(abort_valid === 1'b0 && txn_active === 1'b1, "R9 full overwrite ok", abort_valid, 0);
        store(8'd108, 16'h0001);
        expect_abort("R9 write overflow", 3'd3, 8'h99);

        send_cmd(2'd1, 8'hA0);
        for (int i = 0; i < 8; i++) load(8'(120 + i), d);
        load(8'd121, d);
        check(abort_valid === 1'b0 && txn_active === 1'b1, "R9 full repeat load ok", abort_valid, 0);
        load(8'd128, d);
        expect_abort("R9 read overflow", 3'd3, 8'hA0);
    endtask

    task automatic t_empty_commit;
        logic [DW-1:0] d;
        int w0;
        send_cmd(2'd1, 8'hB0);
        load(8'h05, d);
        w0 = wr_cnt;
        send_cmd(2'd2, 8'h00);
        check(txn_active === 1'b0 && core_ready === 1'b1 && mem_we === 1'b0,
              "R11 empty commit idle", txn_active, 0);
        @(negedge clk);
        check(wr_cnt == w0 && abort_valid === 1'b0, "R11 no write", wr_cnt, w0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_path();
        t_commit();
        t_conflicts();
        t_explicit();
        t_overflow();
        t_empty_commit();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule